// File: doc/BRIEF.md
# Memory-Mapped Pin Controller with Per-Pin Interrupts

This block controls up to 32 general-purpose pins through a plain 32-bit register bus. A bus access is a single cycle: write data is captured on the clock edge while select and write are high. Read data is combinational and depends on the address while select is high. Bit n of every register belongs to pin n.

For each pin, software sets an input enable, an output enable, an output value and an output inversion bit. It can read back the synchronized input level. Each pin has four interrupt sources: rising edge, falling edge, high level and low level. Every source has its own enable bit and a sticky pending bit that software clears by writing a 1. A pin's interrupt line is high while any of its pending bits is set together with the matching enable bit.

Pending bits record events even while their enable is clear, so unmasking a source can raise the interrupt at once. Level sources set their pending bit again on every cycle the condition holds. Software can therefore clear a level source after servicing it without losing a condition that is still active.

Top module: `gpio_event_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe`, `pin_out` and `irq` are all 0, and so every pin starts undriven, with input off and all sources masked.
- R2: The following registers read back the last value written to them: input enable (0x04), output enable (0x08), output value (0x0C), output invert (0x40), rise enable (0x18), fall enable (0x20), high enable (0x28) and low enable (0x30). Offsets that are not mapped read 0.
- R3: `pin_oe` equals the output enable register. `pin_out[n]` is output value XOR output invert for pin n while its output enable is 1, and 0 otherwise.
- R4: The input value register (0x00) returns the pin level after a two-flop synchronizer, ANDed with input enable. A pin change applied before clock edge k is visible after edge k+1.
- R5: While input enable is 1, a synchronized 0→1 transition sets the rise pending bit (0x1C) and a 1→0 transition sets the fall pending bit (0x24). With input enable at 0, no transition is recorded.
- R6: While input enable is 1, the high pending bit (0x2C) is set on each cycle the synchronized pin is 1, and the low pending bit (0x34) on each cycle it is 0. A cleared level bit sets again while its condition persists.
- R7: Pending bits are sticky. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R8: Pending bits record events whatever the state of their enable bits. `irq[n]` is the OR over the four sources of (pending AND enable) for pin n, so enabling a source whose bit is already pending raises `irq[n]` at once.
- R9: Every pin works independently: its registers, output drive and interrupt line depend only on its own bits and its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not selected) |
| pin_in | input | NPINS (32) | Pad input levels, asynchronous |
| pin_out | output | NPINS (32) | Level driven to each pad |
| pin_oe | output | NPINS (32) | Drive enable for each pad |
| irq | output | NPINS (32) | Interrupt line for each pin |

## Verification
Directed cases toggle single pins with input enable off and then on. This separates edge recording from input gating and confirms two-edge synchronizer latency at the readback port. Targeted writes of 0 and then 1 to pending registers while levels persist separate sticky-clear behaviour from level re-arming. A late enable of an already-pending source shows that recording is independent of masking. A random mix of pin patterns and register writes is then compared, register by register and line by line, against a bench model of all pins together, which exposes any cross-pin coupling or wrong source selection.

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] irq
);
  localparam logic [AW-1:0] A_IN  = AW'('h00);
  localparam logic [AW-1:0] A_IEN = AW'('h04);
  localparam logic [AW-1:0] A_OEN = AW'('h08);
  localparam logic [AW-1:0] A_OV  = AW'('h0C);
  localparam logic [AW-1:0] A_RE  = AW'('h18);
  localparam logic [AW-1:0] A_RP  = AW'('h1C);
  localparam logic [AW-1:0] A_FE  = AW'('h20);
  localparam logic [AW-1:0] A_FP  = AW'('h24);
  localparam logic [AW-1:0] A_HE  = AW'('h28);
  localparam logic [AW-1:0] A_HP  = AW'('h2C);
  localparam logic [AW-1:0] A_LE  = AW'('h30);
  localparam logic [AW-1:0] A_LP  = AW'('h34);
  localparam logic [AW-1:0] A_INV = AW'('h40);

  logic [NPINS-1:0] ien, oen, oval, oinv;
  logic [NPINS-1:0] rie, fie, hie, lie;
  logic [NPINS-1:0] rip, fip, hip, lip;
  logic [NPINS-1:0] s1, s2, s3;
  logic [NPINS-1:0] wd, rd;
  logic [NPINS-1:0] rise_ev, fall_ev, high_ev, low_ev;
  logic wr;

  assign wr = bus_sel & bus_we;
  assign wd = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
    end
  end

  assign rise_ev = ien &  s2 & ~s3;
  assign fall_ev = ien & ~s2 &  s3;
  assign high_ev = ien &  s2;
  assign low_ev  = ien & ~s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien <= '0; oen <= '0; oval <= '0; oinv <= '0;
      rie <= '0; fie <= '0; hie <= '0; lie <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_IEN: ien  <= wd;
        A_OEN: oen  <= wd;
        A_OV:  oval <= wd;
        A_INV: oinv <= wd;
        A_RE:  rie  <= wd;
        A_FE:  fie  <= wd;
        A_HE:  hie  <= wd;
        A_LE:  lie  <= wd;
        default: ;
      endcase
    end
  end

  function automatic logic [NPINS-1:0] clr_mask(input logic [AW-1:0] a);
    return (wr && bus_addr == a) ? wd : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rip <= '0; fip <= '0; hip <= '0; lip <= '0;
    end else begin
      rip <= (rip & ~clr_mask(A_RP)) | rise_ev;
      fip <= (fip & ~clr_mask(A_FP)) | fall_ev;
      hip <= (hip & ~clr_mask(A_HP)) | high_ev;
      lip <= (lip & ~clr_mask(A_LP)) | low_ev;
    end
  end

  assign pin_oe  = oen;
  assign pin_out = (oval ^ oinv) & oen;
  assign irq     = (rip & rie) | (fip & fie) | (hip & hie) | (lip & lie);

  always_comb begin
    case (bus_addr)
      A_IN:  rd = s2 & ien;
      A_IEN: rd = ien;
      A_OEN: rd = oen;
      A_OV:  rd = oval;
      A_INV: rd = oinv;
      A_RE:  rd = rie;
      A_RP:  rd = rip;
      A_FE:  rd = fie;
      A_FP:  rd = fip;
      A_HE:  rd = hie;
      A_HP:  rd = hip;
      A_LE:  rd = lie;
      A_LP:  rd = lip;
      default: rd = '0;
    endcase
  end
  assign bus_rdata = bus_sel ? 32'(rd) : 32'h0;

  // R7: pending bits drop only on a clearing write
  a_r7_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_RP) |=> (($past(rip) & ~rip) == '0));
  a_r7_high_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_HP) |=> (($past(hip) & ~hip) == '0));
  // R7: a written 1 clears unless an event arrives in the same cycle
  a_r7_fall_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_FP) |=> ((fip & $past(wd & ~fall_ev)) == '0));
  // R5: no edge is recorded on a pin whose input is disabled
  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ien & ~rip) != '0) |=> ((~$past(ien) & ~$past(rip) & rip) == '0));
  // R6: a high enabled pin leaves its high pending bit set
  a_r6_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien & s2) != '0) |=> (($past(ien & s2) & ~hip) == '0));
  // R8: an interrupt line needs a pending source
  a_r8_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~(rip | fip | hip | lip)) == '0));
endmodule

// File: tb/gpio_event_ctrl_test.sv
`timescale 1ns/1ps
module gpio_event_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_ien, m_oen, m_ov, m_inv, m_re, m_fe, m_he, m_le;
  logic [31:0] m_rp, m_fp, m_hp, m_lp, m_pins;

  always #2.5 clk = ~clk;

  gpio_event_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return m_pins & m_ien;
      8'h04: return m_ien;  8'h08: return m_oen;
      8'h0C: return m_ov;   8'h40: return m_inv;
      8'h18: return m_re;   8'h1C: return m_rp;
      8'h20: return m_fe;   8'h24: return m_fp;
      8'h28: return m_he;   8'h2C: return m_hp;
      8'h30: return m_le;   8'h34: return m_lp;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] addr_of(input int i);
    case (i)
      0: return 8'h04;  1: return 8'h08;  2: return 8'h0C;  3: return 8'h40;
      4: return 8'h18;  5: return 8'h1C;  6: return 8'h20;  7: return 8'h24;
      8: return 8'h28;  9: return 8'h2C;  10: return 8'h30; 11: return 8'h34;
      12: return 8'h00; 13: return 8'h10; default: return 8'h44;
    endcase
  endfunction

  function automatic logic [31:0] m_irq();
    return (m_rp & m_re) | (m_fp & m_fe) | (m_hp & m_he) | (m_lp & m_le);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_levels();
    m_hp |= m_ien & m_pins;
    m_lp |= m_ien & ~m_pins;
  endtask

  task automatic model_pins(input logic [31:0] p);
    m_rp |= m_ien & ~m_pins & p;
    m_fp |= m_ien & m_pins & ~p;
    m_pins = p;
    model_levels();
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    case (a)
      8'h04: m_ien = d;  8'h08: m_oen = d;  8'h0C: m_ov = d;  8'h40: m_inv = d;
      8'h18: m_re = d;   8'h20: m_fe = d;   8'h28: m_he = d;  8'h30: m_le = d;
      8'h1C: m_rp &= ~d; 8'h24: m_fp &= ~d; 8'h2C: m_hp &= ~d; 8'h34: m_lp &= ~d;
      default: ;
    endcase
    model_levels();
    settle();
  endtask

  task automatic do_pins(input logic [31:0] p);
    @(negedge clk);
    pin_in = p;
    settle();
    model_pins(p);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 15; i++) begin
      do_read(addr_of(i), v);
      chk($sformatf("%s reg %h", tag, addr_of(i)), v, mread(addr_of(i)));
    end
    chk({tag, " pin_oe"}, pin_oe, m_oen);
    chk({tag, " pin_out"}, pin_out, (m_ov ^ m_inv) & m_oen);
    chk({tag, " irq"}, irq, m_irq());
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    {m_ien, m_oen, m_ov, m_inv, m_re, m_fe, m_he, m_le} = '0;
    {m_rp, m_fp, m_hp, m_lp, m_pins} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check_all("R1");

    // R2 readback, R3 output drive
    do_write(8'h08, 32'h0000_00FF);
    do_write(8'h0C, 32'h0000_000F);
    do_write(8'h40, 32'h0000_0033);
    do_read(8'h40, v);  chk("R2 invert readback", v, 32'h33);
    do_read(8'h10, v);  chk("R2 unmapped", v, 32'h0);
    chk("R3 pin_out", pin_out, 32'h3C);
    chk("R3 pin_oe", pin_oe, 32'hFF);

    // R4 gated input and R5 no edge while disabled
    do_pins(32'h5);
    do_read(8'h00, v);  chk("R4 gated input", v, 32'h0);
    do_read(8'h1C, v);  chk("R5 no rise while disabled", v, 32'h0);
    do_write(8'h04, 32'hFFFF_FFFF);
    do_read(8'h00, v);  chk("R4 enabled input", v, 32'h5);

    // R4 synchronizer latency
    @(negedge clk);
    pin_in = 32'h105; bus_sel = 1; bus_we = 0; bus_addr = 8'h00;
    @(negedge clk);
    chk("R4 one edge", bus_rdata, 32'h5);
    @(negedge clk);
    chk("R4 two edges", bus_rdata, 32'h105);
    bus_sel = 0;
    settle();
    model_pins(32'h105);
    do_read(8'h1C, v);  chk("R5 rise pin8", v, 32'h100);

    // R7 clear, R6 re-arm of levels
    do_write(8'h1C, 32'hFFFF_FFFF);
    do_write(8'h2C, 32'hFFFF_FFFF);
    do_write(8'h34, 32'hFFFF_FFFF);
    do_read(8'h1C, v);  chk("R7 rise cleared", v, 32'h0);
    do_read(8'h2C, v);  chk("R6 high re-armed", v, 32'h105);
    do_read(8'h34, v);  chk("R6 low re-armed", v, ~32'h105);

    // R5 fall, R7 write of zero keeps bit
    do_pins(32'h104);
    do_read(8'h24, v);  chk("R5 fall pin0", v, 32'h1);
    do_write(8'h24, 32'h0);
    do_read(8'h24, v);  chk("R7 zero write keeps", v, 32'h1);

    // R8 late enable, R9 single line
    do_pins(32'h106);
    chk("R8 masked", irq, 32'h0);
    do_write(8'h18, 32'h2);
    chk("R8 late enable", irq, 32'h2);
    check_all("R9 directed");

    // R9 random mix
    for (int it = 0; it < 300; it++) begin
      if ($urandom_range(0, 2) == 0)
        do_pins($urandom);
      else
        do_write(addr_of($urandom_range(0, 11)), $urandom);
      check_all("R9 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule